// File: doc/BRIEF.md
# Two-Stage Programmable Clock Prescaler

This block turns a single system clock into count-enable ticks for a set of timer channels. Each tick is a one-cycle-wide enable pulse, not a derived clock. The channel counters stay on the system clock and advance only in cycles where their tick is high.

Division runs in two stages. A first stage counts system clocks and fires once every m cycles. Its 5-bit ratio field k selects m = k + 1, so m runs from 1 to 32. A second stage, one per channel, counts first-stage ticks and passes on one out of every 2^n, with n from 0 to 5.

There are three kinds of channel. A group of channels shares one first stage, so every channel in the group divides by the same m; each of those channels still has its own second stage. Other channels each own a private first stage and a second stage. A last kind uses a private first stage only.

Top module: `two_stage_prescaler`

## Requirements
- R1: While `rst_n` is low, every tick output is 0, and it stays 0 for the first two rising edges after `rst_n` goes high. The clock cycle after those two edges is the first one in which a tick can appear.
- R2: A first stage with ratio field k ticks once every k+1 clocks. A field of 0 ticks on every clock. The first tick after reset falls in the first active cycle.
- R3: The ratio field is sampled only in a cycle in which its first stage ticks, and the sampled value sets the length of the next period. A change made between ticks never shortens or stretches the period already running.
- R4: All group channels take their first-stage ticks from one divider set by `grp_ratio_i`. Group channels with equal power settings tick in the same cycles.
- R5: Each private channel divides by its own field in `own_ratio_i` (channel j uses bits [5j+4:5j]), independently of the group and of the other private channels.
- R6: With power field n = 0, a second stage outputs every first-stage tick unchanged.
- R7: Each second stage holds a 5-bit counter that starts at 0 after reset, increments on each first-stage tick and wraps from 31 to 0. It outputs a tick when a first-stage tick is present and the low n bits of the counter are all ones.
- R8: The 3-bit power field (channel c uses bits [3c+2:3c]) is sampled only on a first-stage tick of that channel. Field values 6 and 7 act as 5.
- R9: A first-stage-only channel drives `base_tick_o` directly from its private divider, set by `base_ratio_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_ratio_i | input | 5 | Ratio field k of the shared first stage |
| grp_pow_i | input | 3*NUM_GRP | Power field n for each group channel |
| own_ratio_i | input | 5*NUM_OWN | Ratio fields of the private two-stage channels |
| own_pow_i | input | 3*NUM_OWN | Power fields of the private two-stage channels |
| base_ratio_i | input | 5*NUM_BASE | Ratio fields of the first-stage-only channels |
| grp_tick_o | output | NUM_GRP | Tick for each group channel |
| own_tick_o | output | NUM_OWN | Tick for each private two-stage channel |
| base_tick_o | output | NUM_BASE | Tick for each first-stage-only channel |

## Verification
Two events can fall in the same cycle: a terminal count, which samples the new ratio and power fields, and a change to those fields. The bench provokes this by changing the fields on many random cycles, including cycles in which a first stage is about to tick. It also switches the power setting while the second-stage counter is partway through its low bits. A behavioural model built from integer counters decides on each clock which ticks the new settings must and must not produce. It is compared against every tick output on every clock, so a setting picked up one cycle early or late shows up as a shifted pulse.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int RATIO_W = 5;
  localparam int POW_W   = 3;
  localparam int SCNT_W  = 5;
  localparam int MAX_POW = 5;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [POW_W-1:0]   pow_t;
  typedef logic [SCNT_W-1:0]  scnt_t;

  // Limit a power field to the largest supported exponent.
  function automatic pow_t clamp_pow(input pow_t raw);
    clamp_pow = (raw > pow_t'(MAX_POW)) ? pow_t'(MAX_POW) : raw;
  endfunction

  // Mask of the low n bits of the second-stage counter.
  function automatic scnt_t low_mask(input pow_t n);
    scnt_t m;
    m = '0;
    for (int b = 0; b < SCNT_W; b++) begin
      if (b < int'(n)) m[b] = 1'b1;
    end
    low_mask = m;
  endfunction
endpackage

// File: rtl/presc_rst_sync.sv
module presc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/presc_ratio_div.sv
module presc_ratio_div
  import presc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_i,
  output logic   tick_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t lim_q, lim_d;
  logic   hit;

  assign hit    = (cnt_q == lim_q);
  assign tick_o = rst_n & hit;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (hit) begin
      cnt_d = '0;
      lim_d = ratio_i;
    end else begin
      cnt_d = cnt_q + ratio_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // R3
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(lim_q));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/presc_pow2_sel.sv
module presc_pow2_sel
  import presc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  pow_t pow_i,
  output logic tick_o
);
  scnt_t cnt_q, cnt_d;
  pow_t  n_q, n_d;
  scnt_t mask;

  assign mask   = low_mask(n_q);
  assign tick_o = tick_i & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    n_d   = n_q;
    if (tick_i) begin
      cnt_d = cnt_q + scnt_t'(1);
      n_d   = clamp_pow(pow_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
    end
  end

  // R7
  needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> tick_i);

  // R8
  pow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(n_q));

  // R8
  pow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= pow_t'(MAX_POW));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/two_stage_prescaler.sv
module two_stage_prescaler
  import presc_pkg::*;
#(
  parameter int NUM_GRP  = 3,
  parameter int NUM_OWN  = 2,
  parameter int NUM_BASE = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [RATIO_W-1:0]          grp_ratio_i,
  input  logic [NUM_GRP*POW_W-1:0]    grp_pow_i,
  input  logic [NUM_OWN*RATIO_W-1:0]  own_ratio_i,
  input  logic [NUM_OWN*POW_W-1:0]    own_pow_i,
  input  logic [NUM_BASE*RATIO_W-1:0] base_ratio_i,
  output logic [NUM_GRP-1:0]          grp_tick_o,
  output logic [NUM_OWN-1:0]          own_tick_o,
  output logic [NUM_BASE-1:0]         base_tick_o
);
  logic rst_sync_n;
  logic grp_base_tick;

  presc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  presc_ratio_div u_grp_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ratio_i (grp_ratio_i),
    .tick_o  (grp_base_tick)
  );

  for (genvar c = 0; c < NUM_GRP; c++) begin : g_grp
    presc_pow2_sel u_sel (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick_i (grp_base_tick),
      .pow_i  (grp_pow_i[c*POW_W +: POW_W]),
      .tick_o (grp_tick_o[c])
    );
  end

  for (genvar j = 0; j < NUM_OWN; j++) begin : g_own
    logic own_base_tick;

    presc_ratio_div u_div (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ratio_i (own_ratio_i[j*RATIO_W +: RATIO_W]),
      .tick_o  (own_base_tick)
    );

    presc_pow2_sel u_sel (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick_i (own_base_tick),
      .pow_i  (own_pow_i[j*POW_W +: POW_W]),
      .tick_o (own_tick_o[j])
    );
  end

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
    presc_ratio_div u_div (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ratio_i (base_ratio_i[b*RATIO_W +: RATIO_W]),
      .tick_o  (base_tick_o[b])
    );
  end

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (grp_tick_o == '0 && own_tick_o == '0 && base_tick_o == '0));

  // R4
  grp_shared_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grp_tick_o != '0) |-> grp_base_tick);
endmodule

// File: tb/two_stage_prescaler_tb.sv
`timescale 1ns/1ps
module two_stage_prescaler_tb;
  localparam int NG = 3;
  localparam int NO = 2;
  localparam int NB = 1;
  localparam int NDIV = 1 + NO + NB;
  localparam int NSEL = NG + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]      grp_ratio;
  logic [NG*3-1:0] grp_pow;
  logic [NO*5-1:0] own_ratio;
  logic [NO*3-1:0] own_pow;
  logic [NB*5-1:0] base_ratio;
  logic [NG-1:0]   grp_tick;
  logic [NO-1:0]   own_tick;
  logic [NB-1:0]   base_tick;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  string phase = "R1";

  // Behavioural reference state
  int sync_cnt = 0;
  int dcnt[NDIV];
  int dlim[NDIV];
  int scnt[NSEL];
  int spow[NSEL];

  always #2.5 clk = ~clk;

  two_stage_prescaler #(.NUM_GRP(NG), .NUM_OWN(NO), .NUM_BASE(NB)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_ratio_i  (grp_ratio),
    .grp_pow_i    (grp_pow),
    .own_ratio_i  (own_ratio),
    .own_pow_i    (own_pow),
    .base_ratio_i (base_ratio),
    .grp_tick_o   (grp_tick),
    .own_tick_o   (own_tick),
    .base_tick_o  (base_tick)
  );

  function automatic int ratio_of(int d);
    if (d == 0) return int'(grp_ratio);
    if (d <= NO) return int'(own_ratio[(d-1)*5 +: 5]);
    return int'(base_ratio[(d-1-NO)*5 +: 5]);
  endfunction

  function automatic int pow_of(int s);
    if (s < NG) return int'(grp_pow[s*3 +: 3]);
    return int'(own_pow[(s-NG)*3 +: 3]);
  endfunction

  function automatic int div_of(int s);
    return (s < NG) ? 0 : 1 + (s - NG);
  endfunction

  function automatic bit div_tick(int d);
    return (sync_cnt >= 2) && (dcnt[d] == dlim[d]);
  endfunction

  function automatic bit sel_tick(int s);
    int m;
    m = (1 << spow[s]) - 1;
    return div_tick(div_of(s)) && ((scnt[s] & m) == m);
  endfunction

  always @(posedge clk) begin
    bit t[NDIV];
    if (!rst_n) begin
      sync_cnt = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt = sync_cnt + 1;
      chk_on = 1'b1;
    end else begin
      for (int d = 0; d < NDIV; d++) t[d] = div_tick(d);
      for (int s = 0; s < NSEL; s++) begin
        if (t[div_of(s)]) begin
          scnt[s] = (scnt[s] + 1) % 32;
          spow[s] = (pow_of(s) > 5) ? 5 : pow_of(s);
        end
      end
      for (int d = 0; d < NDIV; d++) begin
        if (t[d]) begin
          dcnt[d] = 0;
          dlim[d] = ratio_of(d);
        end else begin
          dcnt[d] = dcnt[d] + 1;
        end
      end
    end
    if (sync_cnt < 2) begin
      for (int d = 0; d < NDIV; d++) begin dcnt[d] = 0; dlim[d] = 0; end
      for (int s = 0; s < NSEL; s++) begin scnt[s] = 0; spow[s] = 0; end
    end
    chk_on = 1'b1;
  end

  task automatic check_vec(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      logic [NG-1:0] eg;
      logic [NO-1:0] eo;
      logic [NB-1:0] eb;
      for (int s = 0; s < NG; s++) eg[s] = sel_tick(s);
      for (int s = 0; s < NO; s++) eo[s] = sel_tick(NG + s);
      for (int b = 0; b < NB; b++) eb[b] = div_tick(1 + NO + b);
      check_vec("grp_tick", int'(grp_tick), int'(eg));
      check_vec("own_tick", int'(own_tick), int'(eo));
      check_vec("base_tick", int'(base_tick), int'(eb));
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_all(int gr, int g0, int g1, int g2, int o0, int o1,
                         int p0, int p1, int br);
    #1;
    grp_ratio  = 5'(gr);
    grp_pow    = {3'(g2), 3'(g1), 3'(g0)};
    own_ratio  = {5'(o1), 5'(o0)};
    own_pow    = {3'(p1), 3'(p0)};
    base_ratio = 5'(br);
  endtask

  task automatic print_summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
    print_summary();
    $finish;
  end

  initial begin
    grp_ratio = '0; grp_pow = '0; own_ratio = '0; own_pow = '0; base_ratio = '0;
    // R1: held in reset, then released; model covers the two sync edges
    phase = "R1";
    cycles(4);
    #1 rst_n = 1'b1;
    cycles(4);
    // R2: all fields zero, every clock ticks
    phase = "R2";
    cycles(20);
    // R2 and R9: distinct ratios per divider
    phase = "R2_R9";
    set_all(4, 0, 0, 0, 2, 6, 0, 0, 3);
    cycles(120);
    // R3: change ratios between and at terminal counts
    phase = "R3";
    for (int i = 0; i < 12; i++) begin
      set_all(i % 7, 0, 0, 0, (i * 5) % 32, 31 - i, 0, 0, (i * 3) % 11);
      cycles(3 + i);
    end
    set_all(31, 0, 0, 0, 31, 0, 0, 0, 31);
    cycles(100);
    // R4: group channels with equal power tick together
    phase = "R4";
    set_all(2, 1, 1, 0, 1, 3, 0, 0, 0);
    cycles(80);
    // R5: private dividers independent of group
    phase = "R5";
    set_all(9, 0, 0, 0, 0, 13, 0, 0, 5);
    cycles(120);
    // R6: n = 0 passes first-stage ticks through
    phase = "R6";
    set_all(3, 0, 0, 0, 1, 2, 0, 0, 1);
    cycles(60);
    // R7: several powers, long enough for counter wrap
    phase = "R7";
    set_all(0, 1, 3, 5, 1, 0, 2, 5, 0);
    cycles(400);
    // R8: out-of-range powers and mid-count changes
    phase = "R8";
    set_all(1, 7, 6, 2, 0, 1, 6, 3, 2);
    cycles(150);
    set_all(1, 2, 0, 4, 0, 1, 1, 7, 2);
    cycles(7);
    set_all(1, 4, 1, 0, 0, 1, 5, 0, 2);
    cycles(150);
    // R1: reset in mid run
    phase = "R1";
    #1 rst_n = 1'b0;
    cycles(3);
    #1 rst_n = 1'b1;
    cycles(30);
    // R3 and R8: random updates coinciding with terminal counts
    phase = "R3_R8";
    for (int i = 0; i < 600; i++) begin
      set_all($urandom % 6, $urandom % 8, $urandom % 8, $urandom % 8,
              $urandom % 5, $urandom % 32, $urandom % 8, $urandom % 8,
              $urandom % 9);
      cycles(1 + ($urandom % 12));
    end
    cycles(20);
    print_summary();
    $finish;
  end
endmodule